// File: doc/BRIEF.md
# Host Data Word Buffer with Watermark Flags

This block is the staging buffer between a register-mapped host data port and the card-side data path of a memory-card controller. It stores 16-bit words, each holding two bytes, and runs in one of two directions. In receive, the card side writes and the host reads. In transmit, the host writes and the card side reads. The strobes from the side that does not own a port in the current direction have no effect.

A single 16-bit configuration word sets both watermarks and turns DMA requests on or off for each direction. The block reports a live almost-full level and a sticky almost-empty flag in a status word, along with sticky overflow and underflow flags. An interrupt line ORs the status bits that the host has unmasked. Two level request lines stand in for the DMA handshake. A soft clear input empties the buffer and wipes the flags without touching the configuration.

Top module: `hbuf_fifo`

## Requirements
- R1: The buffer holds up to 32 words of 16 bits and returns them in first-in first-out order. Bits 7:0 (low byte) and bits 15:8 (high byte) of each word come back unchanged. `level` gives the occupancy after every clock edge. A popped word appears on the read data output after the edge that pops it.
- R2: When `xfer_tx`=0, `card_wr` pushes `card_wdata` and `host_rd` pops. When `xfer_tx`=1, `host_wr` pushes `host_wdata` and `card_rd` pops. `host_wr`, `card_rd`, `card_wr` and `host_rd` have no effect in the direction that does not use them.
- R3: A push into a full buffer is dropped. It sets the sticky overflow flag, status bit 1.
- R4: A pop from an empty buffer leaves the read data at the last popped word. It sets the sticky underflow flag, status bit 2.
- R5: The configuration word reads back as written. Bit 15 enables receive DMA. Bits 14:8 hold the almost-full threshold. Bit 7 enables transmit DMA. Bits 6:0 hold the almost-empty threshold. Its reset value is 0.
- R6: Status bit 10 (almost-full) is live and high while `level` is greater than the almost-full threshold.
- R7: Status bit 11 (almost-empty) is sticky. Each edge at which the pre-edge occupancy is at or below the almost-empty threshold sets it. Writing a 1 to bit 11 through the status clear port clears it, but a set in the same edge wins over the clear. Bits 1 and 2 are cleared the same way.
- R8: `irq` is high when any status bit is set whose matching bit in `irq_en` is also set.
- R9: `dma_rx_req` is high when receive DMA is enabled, `xfer_tx`=0 and almost-full holds. `dma_tx_req` is high when transmit DMA is enabled, `xfer_tx`=1 and `level` is at or below the almost-empty threshold.
- R10: After reset, the buffer is empty and the status flags, read data and configuration are zero. One edge with `soft_clr` high empties the buffer and clears status bits 1, 2 and 11, but keeps the configuration.
- R11: In receive, the host can drain every word still buffered after the card side stops writing.
- R12: A push and a pop in the same edge on a full buffer are both accepted. The level stays at 32 and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous buffer and flag clear |
| xfer_tx | input | 1 | Direction: 1 transmit, 0 receive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_q | output | 16 | Configuration readback |
| host_wr | input | 1 | Host push strobe (transmit) |
| host_wdata | input | 16 | Host push word |
| host_rd | input | 1 | Host pop strobe (receive) |
| host_rdata | output | 16 | Last popped word, host side |
| card_wr | input | 1 | Card push strobe (receive) |
| card_wdata | input | 16 | Card push word |
| card_rd | input | 1 | Card pop strobe (transmit) |
| card_rdata | output | 16 | Last popped word, card side |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| stat_clr_data | input | 16 | Bits to clear |
| stat_word | output | 16 | Status flags |
| irq_en | input | 16 | Interrupt enable mask |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| level | output | 6 | Current occupancy |

## Verification
The in-RTL assertions assume that every input is synchronous to `clk` and known from reset onward. They assume nothing about strobe combinations: pushes into a full buffer, pops from an empty one, clears that collide with sets, and direction changes in mid-stream are all legal. The bench sets every input to a known value before reset is released. It changes inputs only shortly after a rising edge. Its random phase deliberately hits those collisions, as well as configuration rewrites and soft clears while traffic is flowing.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  localparam int DATA_W = 16;

  // status word bit positions
  localparam int ST_OVF = 1;
  localparam int ST_UNF = 2;
  localparam int ST_AF  = 10;
  localparam int ST_AE  = 11;

  localparam logic [DATA_W-1:0] STICKY_MASK =
    (DATA_W'(1) << ST_OVF) | (DATA_W'(1) << ST_UNF) | (DATA_W'(1) << ST_AE);

  // configuration word, MSB first: bit15 rx dma, 14:8 af thr, bit7 tx dma, 6:0 ae thr
  typedef struct packed {
    logic       rx_dma;
    logic [6:0] af_thr;
    logic       tx_dma;
    logic [6:0] ae_thr;
  } hbuf_cfg_t;
endpackage

// File: rtl/hbuf_store.sv
module hbuf_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [CW-1:0]    count,
  output logic [WIDTH-1:0] rd_word,
  output logic             push_drop,
  output logic             pop_miss
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic [WIDTH-1:0] rd_q, rd_d;
  logic             pop_ok, push_ok, wr_en;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    pop_ok    = pop && (count_q != '0);
    push_ok   = push && ((count_q != CW'(DEPTH)) || pop_ok);
    push_drop = push && !push_ok && !soft_clr;
    pop_miss  = pop && !pop_ok && !soft_clr;
    wr_en     = push_ok && !soft_clr;
    wptr_d    = wptr_q;
    rptr_d    = rptr_q;
    count_d   = count_q;
    rd_d      = rd_q;
    if (soft_clr) begin
      wptr_d  = '0;
      rptr_d  = '0;
      count_d = '0;
    end else begin
      if (pop_ok) begin
        rd_d   = mem[rptr_q];
        rptr_d = ptr_inc(rptr_q);
      end
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      count_d = count_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      rd_q    <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      count_q <= count_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= push_data;
  end

  assign count   = count_q;
  assign rd_word = rd_q;

  // R3: occupancy never passes the depth
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R4: an empty pop leaves the read word alone
  a_r4_hold_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count_q == '0 && !soft_clr) |=> $stable(rd_q));
  // R10: soft clear empties in one edge
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (count_q == '0));
  // R12: swap on full keeps it full
  a_r12_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(DEPTH) && push && pop && !soft_clr) |=> (count_q == CW'(DEPTH)));
endmodule

// File: rtl/hbuf_cfg.sv
module hbuf_cfg
  import hbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output hbuf_cfg_t         cfg
);
  hbuf_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = hbuf_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R5: a write lands whole on the next edge
  a_r5_cfg_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (DATA_W'(cfg_q) == $past(wdata)));
endmodule

// File: rtl/hbuf_status.sv
module hbuf_status
  import hbuf_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              xfer_tx,
  input  logic [CW-1:0]     level,
  input  hbuf_cfg_t         cfg,
  input  logic              push_drop,
  input  logic              pop_miss,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  input  logic [DATA_W-1:0] irq_en,
  output logic [DATA_W-1:0] stat_word,
  output logic              irq,
  output logic              dma_rx_req,
  output logic              dma_tx_req
);
  logic [DATA_W-1:0] st_q, st_d, set_vec, clr_vec;
  logic              af_live, ae_cond;

  always_comb begin
    af_live = 32'(level) > 32'(cfg.af_thr);
    ae_cond = 32'(level) <= 32'(cfg.ae_thr);
    set_vec         = '0;
    set_vec[ST_AE]  = ae_cond;
    set_vec[ST_OVF] = push_drop;
    set_vec[ST_UNF] = pop_miss;
    clr_vec = clr_we ? clr_data : '0;
    if (soft_clr) st_d = '0;
    else          st_d = ((st_q & ~clr_vec) | set_vec) & STICKY_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign stat_word  = st_q | (DATA_W'(af_live) << ST_AF);
  assign irq        = |(stat_word & irq_en);
  assign dma_rx_req = cfg.rx_dma & ~xfer_tx & af_live;
  assign dma_tx_req = cfg.tx_dma & xfer_tx & ae_cond;

  // R3: a dropped push is flagged
  a_r3_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> stat_word[ST_OVF]);
  // R4: an empty pop is flagged
  a_r4_miss_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    pop_miss |=> stat_word[ST_UNF]);
  // R7: almost-empty stays until cleared
  a_r7_ae_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[ST_AE] && !(clr_we && clr_data[ST_AE]) && !soft_clr) |=> stat_word[ST_AE]);
  // R10: soft clear wipes sticky flags
  a_r10_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> ((stat_word & STICKY_MASK) == '0));
endmodule

// File: rtl/hbuf_fifo.sv
module hbuf_fifo
  import hbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              xfer_tx,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_q,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              card_wr,
  input  logic [DATA_W-1:0] card_wdata,
  input  logic              card_rd,
  output logic [DATA_W-1:0] card_rdata,
  input  logic              stat_clr_we,
  input  logic [DATA_W-1:0] stat_clr_data,
  output logic [DATA_W-1:0] stat_word,
  input  logic [DATA_W-1:0] irq_en,
  output logic              irq,
  output logic              dma_rx_req,
  output logic              dma_tx_req,
  output logic [CW-1:0]     level
);
  hbuf_cfg_t         cfg;
  logic              push, pop, push_drop, pop_miss;
  logic [DATA_W-1:0] push_data, rd_word;
  logic [CW-1:0]     count;

  // direction steering: transmit is fed by the host, receive by the card
  always_comb begin
    if (xfer_tx) begin
      push      = host_wr;
      push_data = host_wdata;
      pop       = card_rd;
    end else begin
      push      = card_wr;
      push_data = card_wdata;
      pop       = host_rd;
    end
  end

  hbuf_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  hbuf_store #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .count     (count),
    .rd_word   (rd_word),
    .push_drop (push_drop),
    .pop_miss  (pop_miss)
  );

  hbuf_status #(.CW(CW)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .xfer_tx    (xfer_tx),
    .level      (count),
    .cfg        (cfg),
    .push_drop  (push_drop),
    .pop_miss   (pop_miss),
    .clr_we     (stat_clr_we),
    .clr_data   (stat_clr_data),
    .irq_en     (irq_en),
    .stat_word  (stat_word),
    .irq        (irq),
    .dma_rx_req (dma_rx_req),
    .dma_tx_req (dma_tx_req)
  );

  assign cfg_q      = DATA_W'(cfg);
  assign host_rdata = rd_word;
  assign card_rdata = rd_word;
  assign level      = count;
endmodule

// File: tb/sim_hbuf_fifo.sv
module sim_hbuf_fifo;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, soft_clr, xfer_tx, cfg_we, host_wr, host_rd, card_wr, card_rd, stat_clr_we;
  logic [15:0] cfg_wdata, host_wdata, card_wdata, stat_clr_data, irq_en;
  logic [15:0] cfg_q, host_rdata, card_rdata, stat_word;
  logic        irq, dma_rx_req, dma_tx_req;
  logic [5:0]  level;

  hbuf_fifo u0 (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .xfer_tx(xfer_tx),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .card_wr(card_wr), .card_wdata(card_wdata), .card_rd(card_rd), .card_rdata(card_rdata),
    .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data), .stat_word(stat_word),
    .irq_en(irq_en), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .level(level)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [15:0] mq[$];
  logic [15:0] m_lw, m_cfg, m_pd;
  bit          m_ovf, m_unf, m_ae, m_pr, m_pu, m_pok, m_uok;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_lw = '0; m_cfg = '0; m_ovf = 0; m_unf = 0; m_ae = 0;
    end else begin
      m_cnt = mq.size();
      m_pr  = xfer_tx ? card_rd : host_rd;
      m_pu  = xfer_tx ? host_wr : card_wr;
      m_pd  = xfer_tx ? host_wdata : card_wdata;
      if (soft_clr) begin
        mq.delete(); m_ovf = 0; m_unf = 0; m_ae = 0;
      end else begin
        m_pok = m_pr && (m_cnt > 0);
        m_uok = m_pu && ((m_cnt < 32) || m_pok);
        m_ae  = (m_ae  && !(stat_clr_we && stat_clr_data[11])) || (m_cnt <= int'(m_cfg[6:0]));
        m_ovf = (m_ovf && !(stat_clr_we && stat_clr_data[1]))  || (m_pu && !m_uok);
        m_unf = (m_unf && !(stat_clr_we && stat_clr_data[2]))  || (m_pr && !m_pok);
        if (m_pok) m_lw = mq.pop_front();
        if (m_uok) mq.push_back(m_pd);
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_af, e_ae_lvl;
      logic [15:0] e_stat;
      e_af = mq.size() > int'(m_cfg[14:8]);
      e_ae_lvl = mq.size() <= int'(m_cfg[6:0]);
      e_stat = '0;
      e_stat[11] = m_ae; e_stat[10] = e_af; e_stat[2] = m_unf; e_stat[1] = m_ovf;
      check("R1", "level", int'(level), mq.size());
      check("R1", "host_rdata", int'(host_rdata), int'(m_lw));
      check("R4", "card_rdata", int'(card_rdata), int'(m_lw));
      check("R5", "cfg_q", int'(cfg_q), int'(m_cfg));
      check("R6", "almost-full", int'(stat_word[10]), int'(e_af));
      check("R7", "almost-empty", int'(stat_word[11]), int'(m_ae));
      check("R3", "overflow", int'(stat_word[1]), int'(m_ovf));
      check("R4", "underflow", int'(stat_word[2]), int'(m_unf));
      check("R7", "stat_word", int'(stat_word), int'(e_stat));
      check("R8", "irq", int'(irq), int'(|(e_stat & irq_en)));
      check("R9", "dma_rx_req", int'(dma_rx_req), int'(m_cfg[15] && !xfer_tx && e_af));
      check("R9", "dma_tx_req", int'(dma_tx_req), int'(m_cfg[7] && xfer_tx && e_ae_lvl));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    host_wr = 0; host_rd = 0; card_wr = 0; card_rd = 0;
    cfg_we = 0; stat_clr_we = 0; soft_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_clr = 0; xfer_tx = 0; cfg_we = 0; host_wr = 0; host_rd = 0;
    card_wr = 0; card_rd = 0; stat_clr_we = 0;
    cfg_wdata = '0; host_wdata = '0; card_wdata = '0; stat_clr_data = '0; irq_en = 16'h0C06;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset level", int'(level), 0);
    check("R10", "reset stat", int'(stat_word), 0);
    check("R10", "reset cfg", int'(cfg_q), 0);
    check("R10", "reset rdata", int'(host_rdata), 0);
    rst_n = 1;
    @(posedge clk); #2;

    cfg_we = 1; cfg_wdata = 16'h9F1F; tick();
    // receive fill, one word too many
    for (int i = 0; i < 33; i++) begin
      card_wr = 1; card_wdata = {8'(8'hA0 + i), 8'(i)}; tick();
    end
    @(negedge clk);
    check("R3", "full level", int'(level), 32);
    check("R3", "overflow set", int'(stat_word[1]), 1);
    check("R9", "rx dma on full", int'(dma_rx_req), 1);
    // R11: drain all after card stops
    for (int i = 0; i < 32; i++) begin
      host_rd = 1; tick();
      @(negedge clk);
      check("R11", "drain word", int'(host_rdata), int'({8'(8'hA0 + i), 8'(i)}));
    end
    host_rd = 1; tick();
    @(negedge clk);
    check("R4", "empty read holds", int'(host_rdata), int'(16'hBF1F));
    check("R4", "underflow set", int'(stat_word[2]), 1);
    @(posedge clk); #2;
    stat_clr_we = 1; stat_clr_data = 16'h0806; tick();
    @(negedge clk);
    check("R3", "overflow cleared", int'(stat_word[1]), 0);
    check("R4", "underflow cleared", int'(stat_word[2]), 0);
    check("R7", "ae set wins", int'(stat_word[11]), 1);

    // transmit direction
    @(posedge clk); #2;
    xfer_tx = 1;
    for (int i = 0; i < 5; i++) begin
      host_wr = 1; card_wr = 1; host_wdata = 16'h1000 + 16'(i); card_wdata = 16'hDEAD; tick();
    end
    @(negedge clk);
    check("R2", "tx level ignores card_wr", int'(level), 5);
    @(posedge clk); #2;
    host_rd = 1; tick();
    @(negedge clk);
    check("R2", "host_rd ignored in tx", int'(level), 5);
    @(posedge clk); #2;
    card_rd = 1; tick();
    @(negedge clk);
    check("R2", "card pops tx word", int'(card_rdata), int'(16'h1000));
    @(posedge clk); #2;
    for (int i = 0; i < 28; i++) begin
      host_wr = 1; host_wdata = 16'h2000 + 16'(i); tick();
    end
    host_wr = 1; card_rd = 1; host_wdata = 16'h3333; tick();
    @(negedge clk);
    check("R12", "swap keeps full", int'(level), 32);
    check("R12", "no overflow on swap", int'(stat_word[1]), 0);
    @(posedge clk); #2;
    soft_clr = 1; tick();
    @(negedge clk);
    check("R10", "soft clear level", int'(level), 0);
    check("R10", "soft clear flags", int'(stat_word & 16'h0806), 0);
    check("R10", "soft clear keeps cfg", int'(cfg_q), int'(16'h9F1F));

    // random traffic
    @(posedge clk); #2;
    for (int c = 0; c < 4000; c++) begin
      if (c % 200 == 0) xfer_tx = $urandom_range(0, 1);
      if (c % 100 == 0) irq_en = 16'($urandom);
      host_wr = $urandom_range(0, 1); host_rd = $urandom_range(0, 1);
      card_wr = $urandom_range(0, 1); card_rd = $urandom_range(0, 1);
      host_wdata = 16'($urandom); card_wdata = 16'($urandom);
      if ($urandom_range(0, 49) == 0) begin
        cfg_we = 1; cfg_wdata = {1'($urandom), 7'($urandom_range(0, 40)), 1'($urandom), 7'($urandom_range(0, 40))};
      end
      if ($urandom_range(0, 19) == 0) begin
        stat_clr_we = 1; stat_clr_data = 16'($urandom);
      end
      if ($urandom_range(0, 299) == 0) soft_clr = 1;
      tick();
    end
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule